// File: doc/BRIEF.md
# Audio Output Power Sequencer

This controller orders the power-up and power-down of a single-supply audio output stage that drives the load through external DC-blocking capacitors. It observes an asynchronous active-low reset, a power-down control bit, a slow-start select bit, a per-sample strobe derived from the frame clock and a one-microsecond strobe. From these it drives the output clamp, a code that sets the output level between ground and the quiescent level, the connection of the output buffers, a slow discharge sink, the audio enable and a flag that tells the register block when writes are accepted.

With slow start selected, power-up holds the outputs clamped to ground for a fixed number of sample periods. It then releases the clamp, connects the buffers and steps the level code up by one every few sample strobes until it reaches full scale. Only then is audio enabled. Without slow start, the buffers connect at once and audio follows after a fixed number of microseconds. Setting the power-down bit from any active state stops audio, disconnects the buffers and turns on the discharge sink. A minimum stay in power-down, in milliseconds, is captured when power-down begins. A power-up request made before that time has elapsed waits until it has.

Top module: `pseq_top`

## Requirements
- R1: While rst_n is low, in any state and without waiting for a clock edge, the outputs are clamp_en=1, buf_conn=0, sink_en=0, audio_en=0, reg_wr_ok=0 and ramp_code=0.
- R2: After reset is released with pdn_bit=1, the block sits in a low-power state with clamp_en=1, buf_conn=0, sink_en=0, audio_en=0, reg_wr_ok=1 and ramp_code=0. Strobes have no effect there. reg_wr_ok is 1 only in low-power states.
- R3: Clearing pdn_bit with slow_start=0 connects the buffers and sets ramp_code to full scale with the clamp off. audio_en stays 0 until FAST_US microsecond strobes have been seen and rises right after the last of them.
- R4: Clearing pdn_bit with slow_start=1 keeps clamp_en=1, buf_conn=0 and ramp_code=0 for CLAMP_SAMPLES sample strobes. After the last of them, clamp_en falls and buf_conn rises.
- R5: During the ramp, after k sample strobes ramp_code equals floor(k / RAMP_DIV). It rises by one at a time and never falls while the buffers stay connected.
- R6: audio_en is 1 only while ramp_code is all ones. On the slow path it rises right after the strobe that brings the code to full scale.
- R7: Setting pdn_bit while the buffers are connected, or during the clamp phase, gives on the next clock audio_en=0, buf_conn=0, clamp_en=0, sink_en=1 and reg_wr_ok=1. ramp_code returns to 0 one clock later.
- R8: hold_ms is captured on the clock that enters the discharge state, and later changes to it are ignored. A power-up request is deferred, with sink_en kept at 1, until hold_ms*US_PER_MS microsecond strobes have been counted since entry. A captured value of 0 defers nothing.
- R9: sink_en and buf_conn are never 1 together, and clamp_en and buf_conn are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_bit | input | 1 | Power-down control bit, 1 requests power-down |
| slow_start | input | 1 | Selects clamp, delay and ramp power-up when 1 |
| hold_ms | input | HOLD_W | Minimum power-down stay in milliseconds |
| smp_tick | input | 1 | One-cycle strobe per sample (frame clock) period |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| clamp_en | output | 1 | Clamp outputs to ground |
| ramp_code | output | RAMP_BITS | Output level code, 0 is ground, all ones is quiescent |
| buf_conn | output | 1 | Connect output buffers |
| sink_en | output | 1 | Enable the slow discharge sink |
| audio_en | output | 1 | Audio path enabled |
| reg_wr_ok | output | 1 | Register writes permitted |

## Verification
The bench builds the block with FAST_US=5, CLAMP_SAMPLES=6, RAMP_BITS=3, RAMP_DIV=2, HOLD_W=3 and US_PER_MS=4. These values make every phase a few strobes long. The bench can then check the outputs after each single strobe of the clamp phase, the fast delay and the full ramp, and compare them with values computed from the strobe count. The small millisecond divider lets it sweep the captured hold over 0 to 3 ms, one microsecond strobe at a time. The short ramp lets it also cut power-up short during the clamp and mid-ramp, and apply reset from the running state.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [2:0] {
      PS_RST   = 3'd0,
      PS_OFF   = 3'd1,
      PS_DRAIN = 3'd2,
      PS_CLAMP = 3'd3,
      PS_RAMP  = 3'd4,
      PS_FAST  = 3'd5,
      PS_RUN   = 3'd6
   } pseq_state_e;

   typedef struct packed {
      logic clamp;
      logic conn;
      logic sink;
      logic audio;
      logic wr_ok;
   } pseq_ctl_t;

   function automatic pseq_ctl_t pseq_ctl_of(input pseq_state_e s);
      pseq_ctl_t c;
      c = '{clamp: 1'b1, conn: 1'b0, sink: 1'b0, audio: 1'b0, wr_ok: 1'b0};
      case (s)
         PS_OFF:   c.wr_ok = 1'b1;
         PS_DRAIN: begin c.clamp = 1'b0; c.sink = 1'b1; c.wr_ok = 1'b1; end
         PS_CLAMP: c.clamp = 1'b1;
         PS_RAMP,
         PS_FAST:  begin c.clamp = 1'b0; c.conn = 1'b1; end
         PS_RUN:   begin c.clamp = 1'b0; c.conn = 1'b1; c.audio = 1'b1; end
         default:  c.clamp = 1'b1;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pseq_evt_count.sv
module pseq_evt_count #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ev,
   output logic done
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] CNT_END = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pseq_evt_count: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (ev && (cnt != CNT_END))
         cnt <= cnt + 1'b1;
   end

   assign done = (cnt == CNT_END);

endmodule

// File: rtl/pseq_hold_timer.sv
module pseq_hold_timer #(
   parameter int unsigned HOLD_W    = 10,
   parameter int unsigned US_PER_MS = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              us_tick,
   input  logic [HOLD_W-1:0] hold_ms,
   output logic              done
);
   localparam logic [HOLD_W-1:0] MS_SAT = '1;

   generate
      if (HOLD_W < 1) begin : g_bad_w
         $error("pseq_hold_timer: HOLD_W must be at least 1");
      end
      if (US_PER_MS < 1) begin : g_bad_div
         $error("pseq_hold_timer: US_PER_MS must be at least 1");
      end
   endgenerate

   logic              ms_step;
   logic [HOLD_W-1:0] ms_cnt;
   logic [HOLD_W-1:0] hold_lat;

   generate
      if (US_PER_MS == 1) begin : g_no_div
         assign ms_step = us_tick;
      end else begin : g_div
         localparam int unsigned SW = $clog2(US_PER_MS);
         localparam logic [SW-1:0] SUB_END = SW'(US_PER_MS - 1);
         logic [SW-1:0] sub;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sub <= '0;
            else if (clr)
               sub <= '0;
            else if (us_tick)
               sub <= (sub == SUB_END) ? '0 : sub + 1'b1;
         end
         assign ms_step = us_tick && (sub == SUB_END);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_cnt   <= '0;
         hold_lat <= '0;
      end else if (clr) begin
         ms_cnt   <= '0;
         hold_lat <= hold_ms;
      end else if (ms_step && (ms_cnt != MS_SAT)) begin
         ms_cnt   <= ms_cnt + 1'b1;
      end
   end

   assign done = (ms_cnt >= hold_lat);

endmodule

// File: rtl/pseq_ramp.sv
module pseq_ramp #(
   parameter int unsigned RAMP_BITS = 10,
   parameter int unsigned RAMP_DIV  = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 force_full,
   input  logic                 smp_tick,
   output logic [RAMP_BITS-1:0] code,
   output logic                 full
);
   localparam logic [RAMP_BITS-1:0] CODE_MAX = '1;

   generate
      if (RAMP_BITS < 1) begin : g_bad_bits
         $error("pseq_ramp: RAMP_BITS must be at least 1");
      end
      if (RAMP_DIV < 1) begin : g_bad_div
         $error("pseq_ramp: RAMP_DIV must be at least 1");
      end
   endgenerate

   logic step;

   generate
      if (RAMP_DIV == 1) begin : g_every_tick
         assign step = run && smp_tick;
      end else begin : g_divided
         localparam int unsigned DW = $clog2(RAMP_DIV);
         localparam logic [DW-1:0] DIV_END = DW'(RAMP_DIV - 1);
         logic [DW-1:0] div_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_cnt <= '0;
            else if (!run)
               div_cnt <= '0;
            else if (smp_tick)
               div_cnt <= (div_cnt == DIV_END) ? '0 : div_cnt + 1'b1;
         end
         assign step = run && smp_tick && (div_cnt == DIV_END);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code <= '0;
      else if (force_full)
         code <= CODE_MAX;
      else if (!run)
         code <= '0;
      else if (step && (code != CODE_MAX))
         code <= code + 1'b1;
   end

   assign full = (code == CODE_MAX);

endmodule

// File: rtl/pseq_top.sv
module pseq_top
   import pseq_pkg::*;
#(
   parameter int unsigned FAST_US       = 50,
   parameter int unsigned CLAMP_SAMPLES = 1000,
   parameter int unsigned RAMP_BITS     = 10,
   parameter int unsigned RAMP_DIV      = 10,
   parameter int unsigned HOLD_W        = 10,
   parameter int unsigned US_PER_MS     = 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pdn_bit,
   input  logic                 slow_start,
   input  logic [HOLD_W-1:0]    hold_ms,
   input  logic                 smp_tick,
   input  logic                 us_tick,
   output logic                 clamp_en,
   output logic [RAMP_BITS-1:0] ramp_code,
   output logic                 buf_conn,
   output logic                 sink_en,
   output logic                 audio_en,
   output logic                 reg_wr_ok
);
   pseq_state_e st_q, st_d;
   pseq_ctl_t   ctl;
   logic        clamp_done, fast_done, hold_done, ramp_full;
   pseq_state_e up_target;

   assign up_target = slow_start ? PS_CLAMP : PS_FAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= PS_RST;
      else
         st_q <= st_d;
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         PS_RST:   st_d = PS_OFF;
         PS_OFF:   if (!pdn_bit) st_d = up_target;
         PS_DRAIN: if (!pdn_bit && hold_done) st_d = up_target;
         PS_CLAMP: if (pdn_bit) st_d = PS_DRAIN;
                   else if (clamp_done) st_d = PS_RAMP;
         PS_RAMP:  if (pdn_bit) st_d = PS_DRAIN;
                   else if (ramp_full) st_d = PS_RUN;
         PS_FAST:  if (pdn_bit) st_d = PS_DRAIN;
                   else if (fast_done) st_d = PS_RUN;
         PS_RUN:   if (pdn_bit) st_d = PS_DRAIN;
         default:  st_d = PS_RST;
      endcase
   end

   pseq_evt_count #(.LIMIT(CLAMP_SAMPLES)) u_clamp_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q != PS_CLAMP),
      .ev    (smp_tick),
      .done  (clamp_done)
   );

   pseq_evt_count #(.LIMIT(FAST_US)) u_fast_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q != PS_FAST),
      .ev    (us_tick),
      .done  (fast_done)
   );

   pseq_hold_timer #(.HOLD_W(HOLD_W), .US_PER_MS(US_PER_MS)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st_q != PS_DRAIN),
      .us_tick (us_tick),
      .hold_ms (hold_ms),
      .done    (hold_done)
   );

   pseq_ramp #(.RAMP_BITS(RAMP_BITS), .RAMP_DIV(RAMP_DIV)) u_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (st_q == PS_RAMP),
      .force_full ((st_q == PS_FAST) || (st_q == PS_RUN)),
      .smp_tick   (smp_tick),
      .code       (ramp_code),
      .full       (ramp_full)
   );

   assign ctl       = pseq_ctl_of(st_q);
   assign clamp_en  = ctl.clamp;
   assign buf_conn  = ctl.conn;
   assign sink_en   = ctl.sink;
   assign audio_en  = ctl.audio;
   assign reg_wr_ok = ctl.wr_ok;

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
   parameter int unsigned RAMP_BITS = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pdn_bit,
   input logic                 clamp_en,
   input logic [RAMP_BITS-1:0] ramp_code,
   input logic                 buf_conn,
   input logic                 sink_en,
   input logic                 audio_en,
   input logic                 reg_wr_ok
);
   localparam logic [RAMP_BITS-1:0] CODE_MAX = '1;

   a_r9_sink_buf_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(sink_en && buf_conn));

   a_r9_clamp_buf_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(clamp_en && buf_conn));

   a_r6_audio_full: assert property (@(posedge clk) disable iff (!rst_n)
      audio_en |-> (ramp_code == CODE_MAX));

   a_r5_ramp_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_conn && $past(buf_conn)) |-> (ramp_code >= $past(ramp_code)));

   a_r7_pdn_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_conn && pdn_bit) |=> (sink_en && !buf_conn && !audio_en && reg_wr_ok));

   a_r2_wr_low_power: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_ok |-> (!buf_conn && !audio_en));

endmodule

bind pseq_top pseq_chk #(.RAMP_BITS(RAMP_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pdn_bit   (pdn_bit),
   .clamp_en  (clamp_en),
   .ramp_code (ramp_code),
   .buf_conn  (buf_conn),
   .sink_en   (sink_en),
   .audio_en  (audio_en),
   .reg_wr_ok (reg_wr_ok)
);

// File: tb/pseq_top_tb.sv
`timescale 1ns/1ps
module pseq_top_tb_top;
   localparam int unsigned FAST_US       = 5;
   localparam int unsigned CLAMP_SAMPLES = 6;
   localparam int unsigned RAMP_BITS     = 3;
   localparam int unsigned RAMP_DIV      = 2;
   localparam int unsigned HOLD_W        = 3;
   localparam int unsigned US_PER_MS     = 4;
   localparam int CODE_MAX  = (1 << RAMP_BITS) - 1;
   localparam int RAMP_TKS  = CODE_MAX * RAMP_DIV;

   // output vector {clamp, buf, sink, audio, wr_ok}
   localparam int O_RST   = 5'b10000;
   localparam int O_OFF   = 5'b10001;
   localparam int O_CLAMP = 5'b10000;
   localparam int O_CONN  = 5'b01000;
   localparam int O_RUN   = 5'b01010;
   localparam int O_DRAIN = 5'b00101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pdn_bit = 1'b1;
   logic slow_start = 1'b0;
   logic [HOLD_W-1:0] hold_ms = '0;
   logic smp_tick = 1'b0;
   logic us_tick = 1'b0;
   logic clamp_en, buf_conn, sink_en, audio_en, reg_wr_ok;
   logic [RAMP_BITS-1:0] ramp_code;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pseq_top #(
      .FAST_US(FAST_US), .CLAMP_SAMPLES(CLAMP_SAMPLES), .RAMP_BITS(RAMP_BITS),
      .RAMP_DIV(RAMP_DIV), .HOLD_W(HOLD_W), .US_PER_MS(US_PER_MS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pdn_bit(pdn_bit), .slow_start(slow_start),
      .hold_ms(hold_ms), .smp_tick(smp_tick), .us_tick(us_tick),
      .clamp_en(clamp_en), .ramp_code(ramp_code), .buf_conn(buf_conn),
      .sink_en(sink_en), .audio_en(audio_en), .reg_wr_ok(reg_wr_ok)
   );

   function automatic int outs();
      return {27'd0, clamp_en, buf_conn, sink_en, audio_en, reg_wr_ok};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick_us();
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
      cyc(2);
   endtask

   task automatic tick_smp();
      @(negedge clk) smp_tick = 1'b1;
      @(negedge clk) smp_tick = 1'b0;
      cyc(2);
   endtask

   task automatic enter_drain(input int h);
      hold_ms = HOLD_W'(h);
      @(negedge clk) pdn_bit = 1'b1;
      cyc(2);
   endtask

   task automatic fast_up();
      slow_start = 1'b0;
      pdn_bit = 1'b0;
      cyc(3);
      repeat (FAST_US) tick_us();
   endtask

   initial begin
      cyc(3);
      chk("R1", "outs in reset", outs(), O_RST);
      chk("R1", "ramp in reset", int'(ramp_code), 0);

      rst_n = 1'b1;
      cyc(3);
      chk("R2", "outs low power", outs(), O_OFF);
      chk("R2", "ramp low power", int'(ramp_code), 0);
      tick_us(); tick_smp();
      chk("R2", "strobes ignored", outs(), O_OFF);

      // fast power-up, audio after FAST_US microsecond strobes
      slow_start = 1'b0;
      pdn_bit = 1'b0;
      cyc(3);
      chk("R3", "outs fast start", outs(), O_CONN);
      chk("R3", "ramp full on fast path", int'(ramp_code), CODE_MAX);
      for (int k = 1; k <= FAST_US; k++) begin
         tick_us();
         chk("R3", $sformatf("audio after %0d us", k), int'(audio_en), (k == FAST_US) ? 1 : 0);
      end
      chk("R3", "outs run", outs(), O_RUN);

      // power-down from run
      @(negedge clk) pdn_bit = 1'b1;
      @(negedge clk);
      chk("R7", "outs drain next clock", outs(), O_DRAIN);
      @(negedge clk);
      chk("R7", "ramp cleared", int'(ramp_code), 0);

      // hold sweep, fast path
      for (int h = 0; h <= 3; h++) begin
         fast_up();
         chk("R8", $sformatf("run before hold %0d", h), outs(), O_RUN);
         enter_drain(h);
         hold_ms = '1;
         pdn_bit = 1'b0;
         cyc(3);
         if (h == 0) begin
            chk("R8", "zero hold not deferred", outs(), O_CONN);
         end else begin
            chk("R8", $sformatf("deferred hold %0d", h), outs(), O_DRAIN);
            for (int k = 1; k <= h * int'(US_PER_MS); k++) begin
               tick_us();
               chk("R8", $sformatf("hold %0d after %0d us", h, k), outs(),
                   (k == h * int'(US_PER_MS)) ? O_CONN : O_DRAIN);
            end
         end
         repeat (FAST_US) tick_us();
         chk("R3", $sformatf("run after hold %0d", h), outs(), O_RUN);
         enter_drain(0);
      end

      // slow power-up with full ramp
      hold_ms = '0;
      slow_start = 1'b1;
      pdn_bit = 1'b0;
      cyc(3);
      chk("R4", "clamp at start", outs(), O_CLAMP);
      chk("R4", "ramp zero at start", int'(ramp_code), 0);
      for (int k = 1; k <= CLAMP_SAMPLES; k++) begin
         tick_smp();
         chk("R4", $sformatf("outs after %0d samples", k), outs(),
             (k == CLAMP_SAMPLES) ? O_CONN : O_CLAMP);
         chk("R4", $sformatf("ramp after %0d samples", k), int'(ramp_code), 0);
      end
      for (int k = 1; k <= RAMP_TKS; k++) begin
         tick_smp();
         chk("R5", $sformatf("ramp code at tick %0d", k), int'(ramp_code), k / int'(RAMP_DIV));
         chk("R6", $sformatf("audio at tick %0d", k), int'(audio_en), (k == RAMP_TKS) ? 1 : 0);
      end
      chk("R6", "outs run after ramp", outs(), O_RUN);

      // power-down mid-ramp
      enter_drain(0);
      pdn_bit = 1'b0;
      cyc(3);
      repeat (CLAMP_SAMPLES) tick_smp();
      repeat (3) tick_smp();
      chk("R5", "ramp mid", int'(ramp_code), 3 / int'(RAMP_DIV));
      @(negedge clk) pdn_bit = 1'b1;
      @(negedge clk);
      chk("R7", "drain from ramp", outs(), O_DRAIN);
      @(negedge clk);
      chk("R7", "ramp cleared from ramp", int'(ramp_code), 0);

      // power-down during clamp
      pdn_bit = 1'b0;
      cyc(3);
      tick_smp(); tick_smp();
      chk("R4", "still clamped", outs(), O_CLAMP);
      @(negedge clk) pdn_bit = 1'b1;
      @(negedge clk);
      chk("R7", "drain from clamp", outs(), O_DRAIN);

      // reset from run
      fast_up();
      chk("R3", "run before reset", outs(), O_RUN);
      @(negedge clk) rst_n = 1'b0;
      pdn_bit = 1'b1;
      #1;
      chk("R1", "outs on reset from run", outs(), O_RST);
      chk("R1", "ramp on reset from run", int'(ramp_code), 0);
      cyc(2);
      rst_n = 1'b1;
      cyc(3);
      chk("R2", "low power after reset", outs(), O_OFF);

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule